// File: doc/BRIEF.md
# Clock-Generator Watchdog Reset Supervisor

This block supervises the frequency selection of a clock generator and drives an active-low reset to the rest of the system. The requested frequency code comes either from the hardware select pins or from a software-programmed code. Whenever the code that is in effect changes, the system reset is pulled low for a fixed number of clock cycles, so that downstream logic restarts cleanly on the new clocks.

A watchdog timer guards against a system that hangs after being over-clocked. While enabled it counts down once per one-second tick from a programmable count, which resets to 16. When it runs out, a sticky status flag is set, the effective frequency code falls back to a programmed safe code, and a reset pulse is issued. Software clears the flag to return to the requested code. Writing the count, or disabling the watchdog, reloads the timer. A count of zero disables expiry.

Top module: `wdt_reset_supervisor`

## Requirements
- R1: `sys_rst_n` is active low; it is low while the block reset `rst_n` is low and stays low for at least RST_CYCLES (default 1024) clock cycles after `rst_n` is released.
- R2: A change of `eff_sel` drives `sys_rst_n` low at the same clock edge, for exactly RST_CYCLES cycles; a new trigger during a pulse restarts the full length. `eff_sel` never changes while `sys_rst_n` is high.
- R3: With `wd_status` = 0, `eff_sel` follows `prog_sel` when `src_prog` = 1 and `pin_sel` when `src_prog` = 0, one cycle after the input; the unselected source has no effect.
- R4: While `wd_en` = 1 the timer falls by one at each cycle where `sec_tick` = 1; it expires on the tick that brings it from 1 to 0, not before.
- R5: After block reset the timeout count is 16, so with no write the watchdog expires on the 16th tick after being enabled.
- R6: On expiry `wd_status` becomes 1, `eff_sel` becomes `safe_sel` and a reset pulse of RST_CYCLES cycles starts, all at the expiry edge.
- R7: `wd_status` stays 1 until a cycle with `stat_clr` = 1; later ticks cause no further pulse, and after clearing, `eff_sel` returns to the requested code.
- R8: A cycle with `tmo_wr` = 1 loads `tmo_wdata` as the new count and reloads the timer with it.
- R9: While `wd_en` = 0 ticks are ignored and the timer is held at the stored count, so re-enabling restarts the full count.
- R10: A stored count of 0 never expires, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| tmo_wr | input | 1 | Write strobe for the timeout count |
| tmo_wdata | input | CNT_W | Timeout count in seconds |
| wd_en | input | 1 | Watchdog enable |
| stat_clr | input | 1 | Clears the expiry status |
| safe_sel | input | SEL_W | Fallback frequency code |
| src_prog | input | 1 | 1 selects the programmed code, 0 the pin code |
| pin_sel | input | SEL_W | Frequency code from the select pins |
| prog_sel | input | SEL_W | Frequency code from software |
| sys_rst_n | output | 1 | Active-low system reset |
| wd_status | output | 1 | Sticky watchdog expiry flag |
| eff_sel | output | SEL_W | Frequency code in effect |

## Verification
The selection path is driven through both sources, with the unselected source toggled to show it is ignored, and a second change placed mid-pulse separates a restarting pulse from one that merely extends or ignores the retrigger. The watchdog is run with the reset-default count, a written count that is rewritten mid-count, an enable dropped mid-count, and a zero count; checking the status one tick before and at the expected expiry tells an off-by-one countdown from a correct one, and a missing reload from a working one. Pulse lengths are measured in cycles after each trigger so that short, long and non-restarted pulses all show up.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic sel_change;
    logic wd_expire;
  } trig_t;

  function automatic logic trig_any(input trig_t t);
    return t.sel_change | t.wd_expire;
  endfunction
endpackage

// File: rtl/wdt_timeout_timer.sv
module wdt_timeout_timer #(
  parameter int CNT_W    = 8,
  parameter int CNT_INIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             wd_en,
  input  logic             tmo_wr,
  input  logic [CNT_W-1:0] tmo_wdata,
  output logic             expire
);
  localparam logic [CNT_W-1:0] INIT_V = CNT_W'(CNT_INIT);

  logic [CNT_W-1:0] tmo_q;
  logic [CNT_W-1:0] timer_q;
  logic [CNT_W-1:0] timer_d;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] t,
                                            input logic tick);
    return (tick && t != '0) ? t - 1'b1 : t;
  endfunction

  always_comb begin
    if (tmo_wr)      timer_d = tmo_wdata;
    else if (!wd_en) timer_d = tmo_q;
    else             timer_d = step(timer_q, sec_tick);
  end

  assign expire = wd_en && !tmo_wr && sec_tick && (timer_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q   <= INIT_V;
      timer_q <= INIT_V;
    end else begin
      if (tmo_wr) tmo_q <= tmo_wdata;
      timer_q <= timer_d;
    end
  end
endmodule

// File: rtl/wdt_sel_ctrl.sv
module wdt_sel_ctrl #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_prog,
  input  logic [SEL_W-1:0] pin_sel,
  input  logic [SEL_W-1:0] prog_sel,
  input  logic [SEL_W-1:0] safe_sel,
  input  logic             expire,
  input  logic             stat_clr,
  output logic [SEL_W-1:0] eff_sel,
  output logic             wd_status,
  output logic             sel_change
);
  logic             status_d;
  logic [SEL_W-1:0] eff_d;

  function automatic logic [SEL_W-1:0] pick(input logic tripped,
                                            input logic use_prog,
                                            input logic [SEL_W-1:0] p_pin,
                                            input logic [SEL_W-1:0] p_prog,
                                            input logic [SEL_W-1:0] p_safe);
    if (tripped)  return p_safe;
    if (use_prog) return p_prog;
    return p_pin;
  endfunction

  assign status_d   = expire | (wd_status & ~stat_clr);
  assign eff_d      = pick(status_d, src_prog, pin_sel, prog_sel, safe_sel);
  assign sel_change = (eff_d != eff_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_status <= 1'b0;
      eff_sel   <= '0;
    end else begin
      wd_status <= status_d;
      eff_sel   <= eff_d;
    end
  end
endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch
  import wdt_pkg::*;
#(
  parameter int RST_CYCLES = 1024
) (
  input  logic  clk,
  input  logic  rst_n,
  input  trig_t trig,
  output logic  sys_rst_n
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(RST_CYCLES);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= LOAD_V;
    else if (trig_any(trig))  left_q <= LOAD_V;
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign sys_rst_n = (left_q == '0);
endmodule

// File: rtl/wdt_reset_supervisor.sv
module wdt_reset_supervisor
  import wdt_pkg::*;
#(
  parameter int SEL_W      = 4,
  parameter int CNT_W      = 8,
  parameter int CNT_INIT   = 16,
  parameter int RST_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             tmo_wr,
  input  logic [CNT_W-1:0] tmo_wdata,
  input  logic             wd_en,
  input  logic             stat_clr,
  input  logic [SEL_W-1:0] safe_sel,
  input  logic             src_prog,
  input  logic [SEL_W-1:0] pin_sel,
  input  logic [SEL_W-1:0] prog_sel,
  output logic             sys_rst_n,
  output logic             wd_status,
  output logic [SEL_W-1:0] eff_sel
);
  logic  expire_evt;
  logic  change_evt;
  trig_t trig;

  wdt_timeout_timer #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wd_en(wd_en),
    .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata), .expire(expire_evt)
  );

  wdt_sel_ctrl #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .src_prog(src_prog), .pin_sel(pin_sel),
    .prog_sel(prog_sel), .safe_sel(safe_sel), .expire(expire_evt),
    .stat_clr(stat_clr), .eff_sel(eff_sel), .wd_status(wd_status),
    .sel_change(change_evt)
  );

  assign trig.sel_change = change_evt;
  assign trig.wd_expire  = expire_evt;

  wdt_rst_stretch #(.RST_CYCLES(RST_CYCLES)) u_stretch (
    .clk(clk), .rst_n(rst_n), .trig(trig), .sys_rst_n(sys_rst_n)
  );
endmodule

// File: rtl/wdt_reset_supervisor_chk.sv
module wdt_reset_supervisor_chk #(
  parameter int SEL_W      = 4,
  parameter int RST_CYCLES = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             wd_en,
  input logic             stat_clr,
  input logic [SEL_W-1:0] safe_sel,
  input logic             sys_rst_n,
  input logic             wd_status,
  input logic [SEL_W-1:0] eff_sel,
  input logic             expire_evt,
  input logic             change_evt
);
  logic [31:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (sys_rst_n)  low_run <= '0;
    else if (low_run != 32'hFFFF_FFFF) low_run <= low_run + 1'b1;
  end

  AST_TRIG_PULLS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt || change_evt) |=> !sys_rst_n); // R2
  AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> low_run >= RST_CYCLES); // R1
  AST_SEL_MOVES_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eff_sel) |-> !sys_rst_n); // R2
  AST_NO_TICK_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |-> !expire_evt); // R4
  AST_EXPIRE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> wd_status); // R6
  AST_SAFE_WHILE_TRIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wd_status |-> eff_sel == $past(safe_sel)); // R6
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_status && !stat_clr) |=> wd_status); // R7
  AST_DISABLED_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |-> !expire_evt); // R9
endmodule

bind wdt_reset_supervisor wdt_reset_supervisor_chk #(
  .SEL_W(SEL_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wd_en(wd_en),
  .stat_clr(stat_clr), .safe_sel(safe_sel), .sys_rst_n(sys_rst_n),
  .wd_status(wd_status), .eff_sel(eff_sel), .expire_evt(expire_evt),
  .change_evt(change_evt)
);

// File: tb/test_wdt_reset_supervisor.sv
`timescale 1ns/1ps
module test_wdt_reset_supervisor;
  localparam int SEL_W = 4;
  localparam int CNT_W = 8;
  localparam int RSTC  = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0, tmo_wr = 1'b0, wd_en = 1'b0, stat_clr = 1'b0;
  logic src_prog = 1'b0;
  logic [CNT_W-1:0] tmo_wdata = '0;
  logic [SEL_W-1:0] safe_sel = 4'd5, pin_sel = '0, prog_sel = '0;
  logic sys_rst_n, wd_status;
  logic [SEL_W-1:0] eff_sel;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_reset_supervisor #(.SEL_W(SEL_W), .CNT_W(CNT_W), .RST_CYCLES(RSTC)) i_wdt_reset_supervisor (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .tmo_wr(tmo_wr),
    .tmo_wdata(tmo_wdata), .wd_en(wd_en), .stat_clr(stat_clr),
    .safe_sel(safe_sel), .src_prog(src_prog), .pin_sel(pin_sel),
    .prog_sel(prog_sel), .sys_rst_n(sys_rst_n), .wd_status(wd_status),
    .eff_sel(eff_sel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic low_len(output int n);
    n = 0;
    while (!sys_rst_n && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic write_count(input int v);
    tmo_wdata = CNT_W'(v);
    tmo_wr = 1'b1;
    @(negedge clk);
    tmo_wr = 1'b0;
  endtask

  task automatic clear_status();
    int n;
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    low_len(n);
  endtask

  task automatic t_reset();
    int n;
    @(negedge clk);
    check("R1 reset low", sys_rst_n, 0);
    check("R1 status at reset", wd_status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    low_len(n);
    check("R1 power-up pulse >= RSTC", int'(n >= RSTC - 1), 1);
    check("R1 released", sys_rst_n, 1);
  endtask

  task automatic t_source();
    int n;
    pin_sel = 4'd3;
    @(negedge clk);
    check("R3 pin source", eff_sel, 3);
    check("R2 reset on change", sys_rst_n, 0);
    low_len(n);
    check("R2 pulse length", n, RSTC);
    prog_sel = 4'd9;
    repeat (3) @(negedge clk);
    check("R3 unselected prog ignored", eff_sel, 3);
    check("R3 no reset from unselected", sys_rst_n, 1);
    src_prog = 1'b1;
    @(negedge clk);
    check("R3 prog source", eff_sel, 9);
    low_len(n);
    check("R2 pulse length prog", n, RSTC);
    pin_sel = 4'd12;
    repeat (3) @(negedge clk);
    check("R3 unselected pin ignored", eff_sel, 9);
    src_prog = 1'b0;
    pin_sel = 4'd3;
    @(negedge clk);
    low_len(n);
  endtask

  task automatic t_retrigger();
    int n;
    pin_sel = 4'd6;
    @(negedge clk);
    repeat (99) @(negedge clk);
    check("R2 still low mid-pulse", sys_rst_n, 0);
    pin_sel = 4'd3;
    low_len(n);
    check("R2 restart full length", n, RSTC + 1);
  endtask

  task automatic t_default_timeout();
    int n;
    wd_en = 1'b1;
    ticks(15);
    check("R5 no expiry at 15 ticks", wd_status, 0);
    check("R4 no reset before expiry", sys_rst_n, 1);
    tick();
    check("R5 expiry at 16th tick", wd_status, 1);
    check("R6 safe code", eff_sel, 5);
    check("R6 reset on expiry", sys_rst_n, 0);
    low_len(n);
    check("R6 pulse length", n, RSTC);
    ticks(20);
    check("R7 status sticky", wd_status, 1);
    check("R7 no further pulse", sys_rst_n, 1);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    check("R7 status cleared", wd_status, 0);
    check("R7 back to requested", eff_sel, 3);
    low_len(n);
    check("R7 pulse on return", n, RSTC);
  endtask

  task automatic t_write();
    write_count(3);
    ticks(2);
    write_count(3);
    ticks(2);
    check("R8 rewrite reloads", wd_status, 0);
    tick();
    check("R8 expiry after written count", wd_status, 1);
    clear_status();
  endtask

  task automatic t_disable();
    wd_en = 1'b0;
    @(negedge clk);
    ticks(5);
    check("R9 ticks ignored when disabled", wd_status, 0);
    wd_en = 1'b1;
    ticks(2);
    wd_en = 1'b0;
    @(negedge clk);
    wd_en = 1'b1;
    ticks(2);
    check("R9 disable reloads", wd_status, 0);
    tick();
    check("R4 expiry on count-th tick", wd_status, 1);
    clear_status();
  endtask

  task automatic t_zero();
    write_count(0);
    ticks(40);
    check("R10 zero never expires", wd_status, 0);
    check("R10 no reset", sys_rst_n, 1);
    check("R10 selection kept", eff_sel, 3);
  endtask

  initial begin
    t_reset();
    t_source();
    t_retrigger();
    t_default_timeout();
    t_write();
    t_disable();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule